// File: doc/BRIEF.md
# SDRAM Power-Up and Refresh Sequencer

This block sits on the host side of an SDRAM command bus and owns that bus from reset until the memory is usable. It then keeps the memory alive. Once reset is released, it drives no-operation commands with clock-enable and both data-mask lines high for a programmable startup pause. It then closes every bank, runs a fixed number of auto-refresh cycles and writes the mode word. Each step waits the clock count the active CAS latency grade requires.

After the mode word has settled, `ready` goes high and the block becomes a periodic refresh source. An interval timer marks refreshes as due. Due refreshes accumulate in a small backlog counter. The block raises `refresh_req` toward a user-side arbiter and sends an auto-refresh command only after `grant` is sampled high. The arbiter gives `grant` once all banks are idle. All clock counts come from the clock period and CAS latency parameters.

Top module: `sdram_init_refresh`

## Requirements
- R1: While reset is held, the command pins (cs_n, ras_n, cas_n, we_n) show NOP = 0111, CKE is high, every DQM bit is high, and `ready`, `refresh_req` and `pending_overflow` are low.
- R2: The reset release is synchronised through two flops. The first command after release is a precharge (0010) with address bit 10 high, which selects all banks. It appears on the pins after clock edge STARTUP_CYC + 2, where STARTUP_CYC = ceil(STARTUP_NS*1000/CLK_PERIOD_PS). Only NOP precedes it, and CKE and DQM stay high for the whole run.
- R3: The first auto-refresh (0001) follows the precharge by exactly tRP edges: 3 for CAS latency 3, 2 for CAS latency 2.
- R4: INIT_REFS auto-refresh commands are issued during initialisation, each exactly tRC edges after the previous one: 9 for CAS latency 3, 7 for CAS latency 2.
- R5: A mode register set (0000) follows the last initial refresh by tRC edges. Its address carries the burst length code in bits 2:0, the burst type in bit 3, the CAS latency in bits 6:4 and the single-write flag in bit 9, with all other bits zero.
- R6: `ready` rises two edges after the mode register set, so at least one NOP follows it, and it never falls afterwards.
- R7: After `ready` rises, a refresh becomes due every REFI_CYC = floor(REFI_NS*1000/CLK_PERIOD_PS) edges, the first one REFI_CYC edges after `ready` rises. `refresh_req` is high while a refresh is due and no refresh is in its tRC window. It stays high until `grant` is seen.
- R8: A steady-state auto-refresh appears on the pins the edge after `grant` is sampled high while `refresh_req` is high, and never without grant.
- R9: With a backlog and `grant` held high, steady-state refreshes come exactly tRC edges apart until the backlog is empty. After that, `refresh_req` is low.
- R10: Up to MAX_PENDING due refreshes are kept. If a refresh comes due while MAX_PENDING are already outstanding, `pending_overflow` rises and stays high until reset, and the backlog stays at MAX_PENDING.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| grant | input | 1 | Arbiter permission to issue the pending refresh |
| cmd_cs_n | output | 1 | Chip select, active low |
| cmd_ras_n | output | 1 | Row strobe, active low |
| cmd_cas_n | output | 1 | Column strobe, active low |
| cmd_we_n | output | 1 | Write enable, active low |
| cmd_cke | output | 1 | Clock enable to memory |
| cmd_dqm | output | DQM_W | Data mask lines |
| cmd_addr | output | ADDR_W | Address pins (precharge-all flag, mode word) |
| cmd_bank | output | BANK_W | Bank select pins |
| ready | output | 1 | Initialisation finished |
| refresh_req | output | 1 | Refresh due and waiting for grant |
| pending_overflow | output | 1 | Sticky flag: a due refresh was lost |

## Verification
The hardest state to reach is the lost-refresh case. It needs the backlog filled to its limit and one more interval to expire before any grant. The bench withholds `grant` across MAX_PENDING+1 intervals and samples the overflow flag on both sides of the edge where it rises. It then releases grant and lets the scoreboard confirm that the saturated backlog drains as exactly MAX_PENDING refreshes, tRC apart, and that the next due refresh still arrives on schedule.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

  // Command pin order: {cs_n, ras_n, cas_n, we_n}
  localparam logic [3:0] CMD_NOP = 4'b0111;
  localparam logic [3:0] CMD_PRE = 4'b0010;
  localparam logic [3:0] CMD_REF = 4'b0001;
  localparam logic [3:0] CMD_MRS = 4'b0000;

  typedef enum logic [2:0] {
    ST_PAUSE,
    ST_PRE_WAIT,
    ST_INIT_REF,
    ST_MRS_WAIT,
    ST_IDLE,
    ST_REF_WAIT
  } seq_state_t;

  // Row precharge time in clocks for a CAS latency grade
  function automatic int trp_clk(input int cl);
    return (cl == 3) ? 3 : 2;
  endfunction

  // Row cycle time in clocks for a CAS latency grade
  function automatic int trc_clk(input int cl);
    return (cl == 3) ? 9 : 7;
  endfunction

endpackage

// File: rtl/seq_countdown.sv
module seq_countdown #(
  parameter int W       = 8,
  parameter int RST_VAL = 0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         en,
  output logic         zero
);

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)                   cnt_d = load_val;
    else if (en && cnt_q != '0) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= W'(RST_VAL);
    else        cnt_q <= cnt_d;
  end

  assign zero = (cnt_q == '0);

endmodule

// File: rtl/refresh_backlog.sv
module refresh_backlog #(
  parameter int INTERVAL  = 1000,
  parameter int MAX_PEND  = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic consume,
  output logic pending_nz,
  output logic overflow
);

  localparam int IV_W   = $clog2(INTERVAL + 1);
  localparam int PEND_W = $clog2(MAX_PEND + 1);

  logic              iv_zero, tick;
  logic [PEND_W-1:0] pend_q, pend_d;
  logic              ovf_q, ovf_d;

  seq_countdown #(.W(IV_W), .RST_VAL(INTERVAL - 1)) u_interval (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (!run || iv_zero),
    .load_val (IV_W'(INTERVAL - 1)),
    .en       (run),
    .zero     (iv_zero)
  );

  assign tick = run && iv_zero;

  always_comb begin
    pend_d = pend_q;
    ovf_d  = ovf_q;
    if (tick && !consume) begin
      if (pend_q == PEND_W'(MAX_PEND)) ovf_d  = 1'b1;
      else                             pend_d = pend_q + 1'b1;
    end else if (!tick && consume) begin
      pend_d = pend_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      ovf_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      ovf_q  <= ovf_d;
    end
  end

  assign pending_nz = (pend_q != '0);
  assign overflow   = ovf_q;

  // R10
  overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_q |=> ovf_q);

  // R8
  consume_has_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    consume |-> pend_q != '0);

endmodule

// File: rtl/sdram_init_refresh.sv
module sdram_init_refresh
  import sdram_seq_pkg::*;
#(
  parameter int         CLK_PERIOD_PS    = 7500,
  parameter int         CAS_LAT          = 3,
  parameter int         STARTUP_NS       = 200000,
  parameter int         REFI_NS          = 15625,
  parameter int         INIT_REFS        = 8,
  parameter int         MAX_PENDING      = 8,
  parameter int         ADDR_W           = 12,
  parameter int         BANK_W           = 2,
  parameter int         DQM_W            = 2,
  parameter logic [2:0] BURST_CODE       = 3'b011,
  parameter logic       BURST_INTERLEAVE = 1'b0,
  parameter logic       SINGLE_WRITE     = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              grant,
  output logic              cmd_cs_n,
  output logic              cmd_ras_n,
  output logic              cmd_cas_n,
  output logic              cmd_we_n,
  output logic              cmd_cke,
  output logic [DQM_W-1:0]  cmd_dqm,
  output logic [ADDR_W-1:0] cmd_addr,
  output logic [BANK_W-1:0] cmd_bank,
  output logic              ready,
  output logic              refresh_req,
  output logic              pending_overflow
);

  localparam int STARTUP_CYC = (STARTUP_NS * 1000 + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS;
  localparam int REFI_CYC    = (REFI_NS * 1000) / CLK_PERIOD_PS;
  localparam int TRP         = trp_clk(CAS_LAT);
  localparam int TRC         = trc_clk(CAS_LAT);
  localparam int TMRD        = 2;
  localparam int TMR_MAX     = (STARTUP_CYC > TRC) ? STARTUP_CYC : TRC;
  localparam int TMR_W       = $clog2(TMR_MAX + 1);
  localparam int RC_W        = $clog2(INIT_REFS + 1);
  localparam logic [ADDR_W-1:0] MODE_WORD =
    ADDR_W'({SINGLE_WRITE, 2'b00, 3'(CAS_LAT), BURST_INTERLEAVE, BURST_CODE});

  // Reset: asserted at once, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_s_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s_n = rst_pipe[1];

  seq_state_t        state_q, state_d;
  logic [3:0]        cmd_q, cmd_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [RC_W-1:0]   rcnt_q, rcnt_d;
  logic              ready_q, ready_d;
  logic              tmr_load, tmr_zero;
  logic [TMR_W-1:0]  tmr_val;
  logic              consume, pend_nz;

  seq_countdown #(.W(TMR_W), .RST_VAL(STARTUP_CYC - 1)) u_step_timer (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .en       (1'b1),
    .zero     (tmr_zero)
  );

  refresh_backlog #(.INTERVAL(REFI_CYC), .MAX_PEND(MAX_PENDING)) u_backlog (
    .clk        (clk),
    .rst_n      (rst_s_n),
    .run        (ready_q),
    .consume    (consume),
    .pending_nz (pend_nz),
    .overflow   (pending_overflow)
  );

  // Next-state and command selection
  always_comb begin
    state_d  = state_q;
    cmd_d    = CMD_NOP;
    addr_d   = '0;
    rcnt_d   = rcnt_q;
    ready_d  = ready_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    consume  = 1'b0;
    case (state_q)
      ST_PAUSE: if (tmr_zero) begin
        cmd_d      = CMD_PRE;
        addr_d[10] = 1'b1;
        tmr_load   = 1'b1;
        tmr_val    = TMR_W'(TRP - 1);
        state_d    = ST_PRE_WAIT;
      end
      ST_PRE_WAIT: if (tmr_zero) begin
        cmd_d    = CMD_REF;
        rcnt_d   = RC_W'(1);
        tmr_load = 1'b1;
        tmr_val  = TMR_W'(TRC - 1);
        state_d  = ST_INIT_REF;
      end
      ST_INIT_REF: if (tmr_zero) begin
        tmr_load = 1'b1;
        if (rcnt_q == RC_W'(INIT_REFS)) begin
          cmd_d   = CMD_MRS;
          addr_d  = MODE_WORD;
          tmr_val = TMR_W'(TMRD - 1);
          state_d = ST_MRS_WAIT;
        end else begin
          cmd_d   = CMD_REF;
          rcnt_d  = rcnt_q + 1'b1;
          tmr_val = TMR_W'(TRC - 1);
        end
      end
      ST_MRS_WAIT: if (tmr_zero) begin
        ready_d = 1'b1;
        state_d = ST_IDLE;
      end
      ST_IDLE: if (pend_nz && grant) begin
        cmd_d    = CMD_REF;
        consume  = 1'b1;
        tmr_load = 1'b1;
        tmr_val  = TMR_W'(TRC - 2);
        state_d  = ST_REF_WAIT;
      end
      ST_REF_WAIT: if (tmr_zero) state_d = ST_IDLE;
      default: state_d = ST_PAUSE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      state_q <= ST_PAUSE;
      cmd_q   <= CMD_NOP;
      addr_q  <= '0;
      rcnt_q  <= '0;
      ready_q <= 1'b0;
    end else begin
      state_q <= state_d;
      cmd_q   <= cmd_d;
      addr_q  <= addr_d;
      rcnt_q  <= rcnt_d;
      ready_q <= ready_d;
    end
  end

  assign {cmd_cs_n, cmd_ras_n, cmd_cas_n, cmd_we_n} = cmd_q;
  assign cmd_addr    = addr_q;
  assign cmd_bank    = '0;
  assign cmd_cke     = 1'b1;
  assign cmd_dqm     = '1;
  assign ready       = ready_q;
  assign refresh_req = (state_q == ST_IDLE) && pend_nz;

  // R6
  ready_stays_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    ready_q |=> ready_q);

  // R6
  mrs_then_nop_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    cmd_q == CMD_MRS |=> cmd_q == CMD_NOP);

  // R8
  ref_needs_grant_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (ready_q && cmd_q == CMD_REF) |-> $past(grant));

  // R7
  req_held_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (refresh_req && !grant) |=> refresh_req);

  // R9
  ref_then_gap_chk: assert property (@(posedge clk) disable iff (!rst_s_n)
    (ready_q && cmd_q == CMD_REF) |=> cmd_q == CMD_NOP);

endmodule

// File: tb/sim_sdram_init_refresh.sv
`timescale 1ps/1ps
module sim_sdram_init_refresh;

  localparam int TCLK_PS  = 7500;
  localparam int STARTUP  = (300 * 1000 + TCLK_PS - 1) / TCLK_PS;  // 40
  localparam int REFI     = (450 * 1000) / TCLK_PS;                // 60
  localparam int SYNC     = 2;
  localparam int T_RP     = 3;
  localparam int T_RC     = 9;
  localparam int N_INIT   = 8;
  localparam int MAXP     = 3;
  localparam logic [3:0] NOP = 4'b0111, PRE = 4'b0010, REF = 4'b0001, MRS = 4'b0000;

  logic clk = 1'b0;
  logic rst_n, grant;
  logic cs_n, ras_n, cas_n, we_n, cke, ready, req, ovf;
  logic [1:0]  dqm, bank;
  logic [11:0] addr;

  always #(TCLK_PS / 2) clk = ~clk;

  sdram_init_refresh #(
    .CLK_PERIOD_PS(TCLK_PS), .CAS_LAT(3), .STARTUP_NS(300), .REFI_NS(450),
    .INIT_REFS(N_INIT), .MAX_PENDING(MAXP)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .grant(grant),
    .cmd_cs_n(cs_n), .cmd_ras_n(ras_n), .cmd_cas_n(cas_n), .cmd_we_n(we_n),
    .cmd_cke(cke), .cmd_dqm(dqm), .cmd_addr(addr), .cmd_bank(bank),
    .ready(ready), .refresh_req(req), .pending_overflow(ovf)
  );

  typedef struct {
    int          edge_no;
    logic [3:0]  cmd;
    logic [11:0] addr;
    logic [11:0] mask;
    string       tag;
  } exp_t;

  exp_t q[$];
  int   tests = 0, failed = 0, pin_bad = 0, edge_cnt = 0;
  bit   done = 0;

  always @(posedge clk) begin
    if (!rst_n) edge_cnt <= 0;
    else        edge_cnt <= edge_cnt + 1;
  end

  task automatic check(input bit ok, input string tag, input string act, input string exp);
    tests++;
    if (!ok) begin
      failed++;
      $display("FAIL %s actual=%s expected=%s", tag, act, exp);
    end
  endtask

  task automatic push(input int e, input logic [3:0] c, input logic [11:0] a,
                      input logic [11:0] m, input string t);
    exp_t it;
    it.edge_no = e; it.cmd = c; it.addr = a; it.mask = m; it.tag = t;
    q.push_back(it);
  endtask

  task automatic at_edge(input int n);
    while (edge_cnt < n) @(negedge clk);
  endtask

  task automatic finish_run;
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  endtask

  // Monitor: pops expected commands and compares
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (cke !== 1'b1 || dqm !== 2'b11) pin_bad++;
      if ({cs_n, ras_n, cas_n, we_n} !== NOP) begin
        if (q.size() == 0) begin
          check(0, "R8 unexpected command",
                $sformatf("cmd=%b edge=%0d", {cs_n, ras_n, cas_n, we_n}, edge_cnt), "none");
        end else begin
          exp_t e;
          e = q.pop_front();
          check(edge_cnt == e.edge_no && {cs_n, ras_n, cas_n, we_n} == e.cmd &&
                (addr & e.mask) == (e.addr & e.mask) && bank == 2'b00, e.tag,
                $sformatf("cmd=%b edge=%0d addr=%h", {cs_n, ras_n, cas_n, we_n}, edge_cnt, addr),
                $sformatf("cmd=%b edge=%0d addr=%h", e.cmd, e.edge_no, e.addr & e.mask));
        end
      end
    end
  end

  initial begin
    #(TCLK_PS * 5000);
    failed++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    int base;
    rst_n = 1'b0;
    grant = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check({cs_n, ras_n, cas_n, we_n} == NOP, "R1 cmd", $sformatf("%b", {cs_n, ras_n, cas_n, we_n}), "0111");
    check(cke == 1'b1 && dqm == 2'b11, "R1 cke/dqm", $sformatf("%b/%b", cke, dqm), "1/11");
    check(!ready && !req && !ovf, "R1 flags", $sformatf("%b%b%b", ready, req, ovf), "000");

    base = STARTUP + SYNC;
    push(base, PRE, 12'h400, 12'h400, "R2 precharge-all");
    for (int i = 0; i < N_INIT; i++)
      push(base + T_RP + i * T_RC, REF, 12'h000, 12'h000, (i == 0) ? "R3 first refresh" : "R4 init refresh");
    push(base + T_RP + N_INIT * T_RC, MRS, 12'h033, 12'hFFF, "R5 mode word");
    rst_n = 1'b1;

    at_edge(118);
    check(!ready, "R6 ready early", $sformatf("%b", ready), "0");
    at_edge(119);
    check(ready, "R6 ready", $sformatf("%b", ready), "1");

    at_edge(119 + REFI - 1);
    check(!req, "R7 req early", $sformatf("%b", req), "0");
    at_edge(119 + REFI);
    check(req, "R7 req due", $sformatf("%b", req), "1");
    at_edge(182);
    check(req, "R7 req held without grant", $sformatf("%b", req), "1");
    push(183, REF, 12'h000, 12'h000, "R8 granted refresh");
    grant = 1'b1;
    at_edge(183);
    grant = 1'b0;
    check(!req, "R8 req cleared", $sformatf("%b", req), "0");

    // Backlog fill: dues at 239, 299, 359 fill, 419 overflows
    at_edge(358);
    check(!ovf, "R10 no overflow yet", $sformatf("%b", ovf), "0");
    at_edge(418);
    check(!ovf, "R10 full but no loss", $sformatf("%b", ovf), "0");
    at_edge(419);
    check(ovf, "R10 overflow", $sformatf("%b", ovf), "1");
    at_edge(422);
    for (int k = 0; k < MAXP; k++)
      push(423 + k * T_RC, REF, 12'h000, 12'h000, "R9 backlog drain");
    push(119 + 6 * REFI + 1, REF, 12'h000, 12'h000, "R10 next due after drain");
    grant = 1'b1;
    at_edge(460);
    check(!req, "R9 backlog empty", $sformatf("%b", req), "0");
    at_edge(500);
    check(q.size() == 0, "R9 all expected commands seen", $sformatf("%0d left", q.size()), "0 left");
    check(pin_bad == 0, "R2 cke/dqm held", $sformatf("%0d bad", pin_bad), "0 bad");
    check(ovf, "R10 overflow sticky", $sformatf("%b", ovf), "1");
    finish_run();
  end

endmodule